// File: doc/BRIEF.md
# PHY Event Interrupt Status and Enable Register

This block is one 16-bit management register of an Ethernet PHY. Six link-related event detectors feed it single-cycle pulses. Each pulse sets a sticky status flag. Each flag has an enable bit of its own in the same word. A single interrupt line is raised when some flag and its enable are both set and the global interrupt-enable input is high. The global enable comes from a separate control register.

The management logic sees the register as address 0x012. A read strobe returns the whole word on the read-data port in the same cycle, and at the end of that cycle every status flag is cleared. A write strobe loads only the enable bits. Flags latch whether or not they are enabled, so software can poll events that it does not want as interrupts.

Top module: `phy_irq_reg`

## Requirements
- R1: While reset is asserted and right after it, the word reads 0x0000 and `irq_o` is low.
- R2: A write strobe loads `wdata_i[5:0]` into the enable bits 5:0. Bit k enables event k: 0 receive-half-full, 1 false-carrier-half-full, 2 autoneg-complete, 3 duplex-change, 4 speed-change, 5 link-change. Without a write strobe the enables keep their value.
- R3: Bits 7:6 and 15:14 always read zero, and writing ones to them has no effect.
- R4: A write leaves the status bits 13:8 unchanged.
- R5: A pulse on `evt_i[k]` sets status bit 8+k after the next clock edge, whether or not enable bit k is set.
- R6: A status bit stays set until a read strobe occurs.
- R7: During a read-strobe cycle, `rdata_o` shows the current word. After that clock edge every status bit is clear, unless R8 applies.
- R8: An event that arrives in the same cycle as a read is not returned by that read, and it is set in the status afterwards.
- R9: `irq_o` is a registered level. After each edge it is high exactly when some status bit and its matching enable bit are both set, and `gie_i` was high at that edge.
- R10: If `gie_i` is low at an edge, `irq_o` is low after that edge.
- R11: `irq_o` falls in the cycle after a clearing read, unless an enabled event arrived in the same cycle as the read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| evt_i | input | 6 | Single-cycle event pulses, bit order as in R2 |
| rd_i | input | 1 | Read strobe; clears status at the clock edge |
| wr_i | input | 1 | Write strobe |
| wdata_i | input | 16 | Write data |
| gie_i | input | 1 | Global interrupt enable |
| rdata_o | output | 16 | Current register word |
| irq_o | output | 1 | Active-high interrupt level |

## Verification
The read-data port is combinational from the register. Its value for a read is therefore due in the strobe cycle itself. Status, enables and `irq_o` change one edge after the stimulus that causes them. The bench drives each vector on a falling edge and samples the pre-edge word one nanosecond later. It then samples the post-edge word and `irq_o` one nanosecond after the rising edge, which keeps every sample away from the active edge. The reset check samples while reset is held and again after the synchronizer has released it.

// File: rtl/phy_irq_pkg.sv
package phy_irq_pkg;
  localparam int unsigned REG_W    = 16;
  localparam int unsigned EVT_N    = 6;
  localparam int unsigned EN_POS   = 0;
  localparam int unsigned STAT_POS = 8;
  localparam logic [4:0]  REG_ADDR = 5'h12;
endpackage

// File: rtl/phy_irq_rst_sync.sv
module phy_irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_no = sync_q[STAGES-1];
endmodule

// File: rtl/phy_irq_status.sv
module phy_irq_status #(
  parameter int unsigned EVT_N = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] evt_i,
  input  logic             clr_i,
  output logic [EVT_N-1:0] stat_o,
  output logic [EVT_N-1:0] stat_nxt_o
);
  logic [EVT_N-1:0] stat_q;

  for (genvar k = 0; k < EVT_N; k++) begin : g_flag
    // a clear never drops an event arriving in the same cycle
    always_comb begin
      stat_nxt_o[k] = (stat_q[k] & ~clr_i) | evt_i[k];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stat_q[k] <= 1'b0;
      else         stat_q[k] <= stat_nxt_o[k];
    end
  end

  assign stat_o = stat_q;
endmodule

// File: rtl/phy_irq_enable.sv
module phy_irq_enable #(
  parameter int unsigned EVT_N = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [EVT_N-1:0] wbits_i,
  output logic [EVT_N-1:0] en_o,
  output logic [EVT_N-1:0] en_nxt_o
);
  logic [EVT_N-1:0] en_q;

  always_comb begin
    en_nxt_o = en_q;
    if (wr_i) en_nxt_o = wbits_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) en_q <= '0;
    else         en_q <= en_nxt_o;
  end

  assign en_o = en_q;
endmodule

// File: rtl/phy_irq_combine.sv
module phy_irq_combine #(
  parameter int unsigned EVT_N = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [EVT_N-1:0] stat_nxt_i,
  input  logic [EVT_N-1:0] en_nxt_i,
  input  logic             gie_i,
  output logic             irq_o
);
  logic irq_d;
  logic irq_q;

  always_comb begin
    irq_d = gie_i & (|(stat_nxt_i & en_nxt_i));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/phy_irq_reg.sv
module phy_irq_reg
  import phy_irq_pkg::*;
#(
  parameter int unsigned DATA_W  = REG_W,
  parameter int unsigned NUM_EVT = EVT_N,
  parameter int unsigned EN_LSB  = EN_POS,
  parameter int unsigned ST_LSB  = STAT_POS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_EVT-1:0] evt_i,
  input  logic               rd_i,
  input  logic               wr_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic               gie_i,
  output logic [DATA_W-1:0]  rdata_o,
  output logic               irq_o
);
  localparam int unsigned EN_MSB = EN_LSB + NUM_EVT - 1;
  localparam int unsigned ST_MSB = ST_LSB + NUM_EVT - 1;

  logic               rst_sync_n;
  logic [NUM_EVT-1:0] status_q;
  logic [NUM_EVT-1:0] status_nxt;
  logic [NUM_EVT-1:0] enable_q;
  logic [NUM_EVT-1:0] enable_nxt;

  phy_irq_rst_sync #(.STAGES(2)) i_rst_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_sync_n)
  );

  phy_irq_status #(.EVT_N(NUM_EVT)) i_status (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .evt_i      (evt_i),
    .clr_i      (rd_i),
    .stat_o     (status_q),
    .stat_nxt_o (status_nxt)
  );

  phy_irq_enable #(.EVT_N(NUM_EVT)) i_enable (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .wr_i     (wr_i),
    .wbits_i  (wdata_i[EN_MSB:EN_LSB]),
    .en_o     (enable_q),
    .en_nxt_o (enable_nxt)
  );

  phy_irq_combine #(.EVT_N(NUM_EVT)) i_combine (
    .clk_i      (clk_i),
    .rst_ni     (rst_sync_n),
    .stat_nxt_i (status_nxt),
    .en_nxt_i   (enable_nxt),
    .gie_i      (gie_i),
    .irq_o      (irq_o)
  );

  // read word: reserved positions are tied to zero
  always_comb begin
    rdata_o                = '0;
    rdata_o[EN_MSB:EN_LSB] = enable_q;
    rdata_o[ST_MSB:ST_LSB] = status_q;
  end
endmodule

// File: rtl/phy_irq_chk.sv
module phy_irq_chk #(
  parameter int unsigned NUM_EVT = 6
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [NUM_EVT-1:0] evt_i,
  input logic               rd_i,
  input logic               wr_i,
  input logic [NUM_EVT-1:0] wbits_i,
  input logic               gie_i,
  input logic [15:0]        rdata_i,
  input logic               irq_i,
  input logic [NUM_EVT-1:0] st_i,
  input logic [NUM_EVT-1:0] en_i
);
  assert_event_sets_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|evt_i) |=> ((st_i & $past(evt_i)) == $past(evt_i)));

  assert_sticky_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> ((st_i & $past(st_i)) == $past(st_i)));

  assert_read_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> (st_i == $past(evt_i)));

  assert_write_loads_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |=> (en_i == $past(wbits_i)));

  assert_enable_holds_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_i));

  assert_write_keeps_status_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !rd_i && evt_i == '0) |=> $stable(st_i));

  assert_reserved_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdata_i[7:6] == 2'b00) && (rdata_i[15:14] == 2'b00));

  assert_gie_gates_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gie_i |=> !irq_i);

  assert_irq_level_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gie_i |=> (irq_i == (|(st_i & en_i))));
endmodule

bind phy_irq_reg phy_irq_chk #(.NUM_EVT(NUM_EVT)) i_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_sync_n),
  .evt_i   (evt_i),
  .rd_i    (rd_i),
  .wr_i    (wr_i),
  .wbits_i (wdata_i[EN_MSB:EN_LSB]),
  .gie_i   (gie_i),
  .rdata_i (rdata_o),
  .irq_i   (irq_o),
  .st_i    (status_q),
  .en_i    (enable_q)
);

// File: tb/test_phy_irq_reg.sv
module test_phy_irq_reg;
  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [5:0]  evt_i;
  logic        rd_i;
  logic        wr_i;
  logic [15:0] wdata_i;
  logic        gie_i;
  logic [15:0] rdata_o;
  logic        irq_o;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  always #2 clk_i = ~clk_i;

  phy_irq_reg i_phy_irq_reg (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_i), .rd_i(rd_i), .wr_i(wr_i),
    .wdata_i(wdata_i), .gie_i(gie_i), .rdata_o(rdata_o), .irq_o(irq_o)
  );

  // fields: rd, wr, wen[5:0], evt[5:0], gie, word before edge, word after edge, irq after edge
  localparam int NV = 12;
  localparam logic [47:0] VEC [NV] = '{
    {1'b0, 1'b1, 6'h01, 6'h00, 1'b1, 16'h0000, 16'h0001, 1'b0}, // R2 enable bit 0
    {1'b0, 1'b0, 6'h00, 6'h02, 1'b1, 16'h0001, 16'h0201, 1'b0}, // R5 latch while disabled
    {1'b0, 1'b0, 6'h00, 6'h01, 1'b1, 16'h0201, 16'h0301, 1'b1}, // R9 enabled event
    {1'b0, 1'b0, 6'h00, 6'h00, 1'b0, 16'h0301, 16'h0301, 1'b0}, // R10 gie low
    {1'b0, 1'b0, 6'h00, 6'h00, 1'b1, 16'h0301, 16'h0301, 1'b1}, // R6 sticky
    {1'b0, 1'b1, 6'h3E, 6'h00, 1'b1, 16'h0301, 16'h033E, 1'b1}, // R4 write keeps status
    {1'b1, 1'b0, 6'h00, 6'h00, 1'b1, 16'h033E, 16'h003E, 1'b0}, // R7 R11 clearing read
    {1'b1, 1'b0, 6'h00, 6'h20, 1'b1, 16'h003E, 16'h203E, 1'b1}, // R8 collision
    {1'b1, 1'b0, 6'h00, 6'h00, 1'b1, 16'h203E, 16'h003E, 1'b0}, // R7 R11
    {1'b0, 1'b0, 6'h00, 6'h3F, 1'b1, 16'h003E, 16'h3F3E, 1'b1}, // R5 all events
    {1'b0, 1'b1, 6'h00, 6'h00, 1'b1, 16'h3F3E, 16'h3F00, 1'b0}, // R2 R9 enables off
    {1'b1, 1'b0, 6'h00, 6'h00, 1'b1, 16'h3F00, 16'h0000, 1'b0}  // R7
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    rd_i = 1'b0; wr_i = 1'b0; evt_i = '0; wdata_i = '0; gie_i = 1'b1;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    idle();
    rst_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    check("R1 word in reset", rdata_o, 16'h0000);
    check("R1 irq in reset", {15'h0, irq_o}, 16'h0000);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    check("R1 word after reset", rdata_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      rd_i    = VEC[i][47];
      wr_i    = VEC[i][46];
      wdata_i = {10'h0, VEC[i][45:40]};
      evt_i   = VEC[i][39:34];
      gie_i   = VEC[i][33];
      #1;
      check($sformatf("R7 vec%0d word before edge", i), rdata_o, VEC[i][32:17]);
      @(posedge clk_i);
      #1;
      idle();
      check($sformatf("R5 R6 vec%0d word after edge", i), rdata_o, VEC[i][16:1]);
      check($sformatf("R9 vec%0d irq", i), {15'h0, irq_o}, {15'h0, VEC[i][0]});
      @(negedge clk_i);
    end

    // R3: ones written to reserved and status positions are ignored
    wr_i = 1'b1; wdata_i = 16'hFFFF;
    @(negedge clk_i);
    idle();
    check("R3 R4 write all ones", rdata_o, 16'h003F);

    // R10: pending enabled event held off by gie, then released
    evt_i = 6'h10; gie_i = 1'b0;
    @(negedge clk_i);
    idle(); gie_i = 1'b0;
    check("R10 irq held by gie", {15'h0, irq_o}, 16'h0000);
    gie_i = 1'b1;
    @(negedge clk_i);
    check("R9 irq after gie rises", {15'h0, irq_o}, 16'h0001);

    // R1: asynchronous reset clears everything at once
    rst_ni = 1'b0;
    #1;
    check("R1 async clear word", rdata_o, 16'h0000);
    check("R1 async clear irq", {15'h0, irq_o}, 16'h0000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    repeat (3) @(negedge clk_i);
    check("R1 word after second reset", rdata_o, 16'h0000);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule